// File: doc/BRIEF.md
# Four-Channel Timer Compare Flag Unit

The unit runs a free-running counter that advances once per timer clock and compares it against four programmable compare values. When the counter equals a compare value, a flag for that channel is set and stays set. It remains set through later matches until software clears it.

Software reaches the unit through a single-cycle register port. A write takes effect on the clock edge that samples the strobe. Read data for the word offset presented in one cycle appears on the data output in the next cycle.

The four flags share one status word. A flag is cleared by writing a one to its bit, and a zero bit in the write leaves the flag alone. Each channel also drives an interrupt line. The line is high while both the flag and that channel's enable bit are set.

The counter width is a parameter with a default of 32 bits. The bench uses a narrower counter so that it can observe wrap-around.

Top module: `tmr_match_unit`

## Requirements
- R1: The counter is zero during reset. It then adds one on every clock and wraps from its all-ones value to zero. Offset 4 reads the counter zero-extended, and writes to offset 4 have no effect.
- R2: Offsets 0 to 3 hold the compare values of channels 0 to 3. Writes keep the low counter-width bits of the write data. Reads return the stored value zero-extended to 32 bits.
- R3: Channel i's flag sits at bit i of offset 5. It becomes one on the clock edge that ends a cycle in which the counter equals that channel's compare value.
- R4: A flag that is one stays one when no clear applies to it, including across later matches.
- R5: A write to offset 5 clears every flag whose data bit is one. Flags whose data bit is zero are left unchanged, so an all-zero write changes nothing.
- R6: If a clear and a match for the same channel fall in the same cycle, the flag is one afterwards.
- R7: Bits 31 to 4 of the status read are always zero. Writing ones to those bits has no effect.
- R8: Offset 6 bits 3 to 0 hold the interrupt enables, and its bits 31 to 4 read as zero. Output irq[i] equals flag i AND enable i.
- R9: Synchronous active-high reset sets all flags, enables and the read data to zero and sets every compare value to all ones.
- R10: The read data output is registered. It shows the word at the offset sampled on the previous clock edge, and offset 7 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the offset on bus_addr |
| bus_addr | input | 3 | Word offset for the read or write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's offset |
| irq | output | 4 | Per-channel interrupt, flag AND enable |

## Verification
The hardest case to reach is a clear that arrives in exactly the cycle in which the counter equals that channel's compare value, because both the counter and the register port must line up on one edge. The bench keeps its own cycle-accurate copy of the counter value. It places a compare value a few counts ahead of that copy, waits until the copy equals the compare value, and presents the clear in that exact cycle. A narrow counter lets the bench step through a whole wrap and check that the flags stay sticky across repeated matches.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NCH    = 4;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int CH_IW  = $clog2(NCH);

    typedef enum logic [ADDR_W-1:0] {
        OFF_CMP0   = 3'd0,
        OFF_COUNT  = 3'd4,
        OFF_STATUS = 3'd5,
        OFF_IRQEN  = 3'd6
    } reg_off_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic logic is_cmp_off(input logic [ADDR_W-1:0] a);
        return (int'(a) < NCH);
    endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_o == $past(cnt_o) + 1'b1)); // R1

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic         clr,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] cmp_o,
    output logic         flag_o
);
    logic [W-1:0] cmp_q;
    logic         flag_q;
    logic         hit;

    assign hit = (cnt == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '1;
            flag_q <= 1'b0;
        end else begin
            if (cmp_we) cmp_q <= cmp_wdata;
            flag_q <= (flag_q & ~clr) | hit;
        end
    end

    assign cmp_o  = cmp_q;
    assign flag_o = flag_q;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        (cnt == cmp_o) |=> flag_o); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr) |=> flag_o); // R4
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr && (cnt != cmp_o)) |=> !flag_o); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (clr && (cnt == cmp_o)) |=> flag_o); // R6

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  bus_req_t                req,
    input  logic [W-1:0]            cnt,
    input  logic [NCH-1:0][W-1:0]   cmp_all,
    input  logic [NCH-1:0]          flags,
    output logic [NCH-1:0]          cmp_we,
    output logic [NCH-1:0]          clr,
    output logic [NCH-1:0]          ien_o,
    output logic [DATA_W-1:0]       rdata_o
);
    logic [NCH-1:0]    ien_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] cnt_ext;
    logic [DATA_W-1:0] cmp_ext;

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        assign cmp_we[i] = req.we && (req.addr == ADDR_W'(i));
        assign clr[i]    = req.we && (req.addr == OFF_STATUS) && req.data[i];
    end

    always_comb begin
        cnt_ext = '0;
        cnt_ext[W-1:0] = cnt;
        cmp_ext = '0;
        cmp_ext[W-1:0] = cmp_all[req.addr[CH_IW-1:0]];
        rd_next = '0;
        if (is_cmp_off(req.addr)) begin
            rd_next = cmp_ext;
        end else begin
            case (req.addr)
                OFF_COUNT:  rd_next = cnt_ext;
                OFF_STATUS: rd_next[NCH-1:0] = flags;
                OFF_IRQEN:  rd_next[NCH-1:0] = ien_q;
                default:    rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (req.we && (req.addr == OFF_IRQEN)) ien_q <= req.data[NCH-1:0];
            rdata_q <= rd_next;
        end
    end

    assign ien_o   = ien_q;
    assign rdata_o = rdata_q;

    AST_STATUS_RSV: assert property (@(posedge clk) disable iff (rst)
        (req.addr == OFF_STATUS) |=> (rdata_o[DATA_W-1:NCH] == '0)); // R7
    AST_COUNT_RD: assert property (@(posedge clk) disable iff (rst)
        (req.addr == OFF_COUNT) |=> (rdata_o[W-1:0] == $past(cnt))); // R10
    AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (rst)
        (req.addr == 3'd7) |=> (rdata_o == '0)); // R10

endmodule

// File: rtl/tmr_match_unit.sv
module tmr_match_unit
    import tmr_pkg::*;
#(
    parameter int TMR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    irq
);
    bus_req_t                  req;
    logic [TMR_W-1:0]          cnt;
    logic [NCH-1:0][TMR_W-1:0] cmp_all;
    logic [NCH-1:0]            flags;
    logic [NCH-1:0]            cmp_we;
    logic [NCH-1:0]            clr;
    logic [NCH-1:0]            ien;

    assign req.we   = bus_we;
    assign req.addr = bus_addr;
    assign req.data = bus_wdata;

    tmr_counter #(.W(TMR_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .cnt_o (cnt)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_chan #(.W(TMR_W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .cmp_we    (cmp_we[i]),
            .cmp_wdata (bus_wdata[TMR_W-1:0]),
            .clr       (clr[i]),
            .cnt       (cnt),
            .cmp_o     (cmp_all[i]),
            .flag_o    (flags[i])
        );
    end

    tmr_regif #(.W(TMR_W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .cnt     (cnt),
        .cmp_all (cmp_all),
        .flags   (flags),
        .cmp_we  (cmp_we),
        .clr     (clr),
        .ien_o   (ien),
        .rdata_o (bus_rdata)
    );

    assign irq = flags & ien;

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == OFF_IRQEN) && (bus_wdata[NCH-1:0] == '0)) |=> (irq == '0)); // R8

endmodule

// File: tb/tmr_match_unit_test.sv
module tmr_match_unit_test;

    localparam int  TW   = 12;
    localparam longint MASK = (64'd1 << TW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int    checks = 0;
    int    errors = 0;
    string phase  = "R9 reset";

    longint      m_cnt = 0;
    longint      m_cmp [4] = '{0, 0, 0, 0};
    logic [3:0]  m_flag = 4'd0;
    logic [3:0]  m_ien  = 4'd0;
    logic [31:0] m_rdata = 32'd0;

    tmr_match_unit #(.TMR_W(TW)) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0, 3'd1, 3'd2, 3'd3: return 32'(m_cmp[a]);
            3'd4: return 32'(m_cnt);
            3'd5: return {28'd0, m_flag};
            3'd6: return {28'd0, m_ien};
            default: return 32'd0;
        endcase
    endfunction

    // Behavioural reference, one step per rising edge
    always @(posedge clk) begin
        logic [31:0] rd;
        logic [3:0]  hit;
        logic [3:0]  clrv;
        if (rst) begin
            m_cnt   = 0;
            m_flag  = 4'd0;
            m_ien   = 4'd0;
            m_rdata = 32'd0;
            for (int i = 0; i < 4; i++) m_cmp[i] = MASK;
        end else begin
            rd = model_read(bus_addr);
            for (int i = 0; i < 4; i++) hit[i] = (m_cnt == m_cmp[i]);
            clrv = (bus_we && bus_addr == 3'd5) ? bus_wdata[3:0] : 4'd0;
            if (bus_we && bus_addr < 3'd4) m_cmp[bus_addr] = longint'(bus_wdata) & MASK;
            if (bus_we && bus_addr == 3'd6) m_ien = bus_wdata[3:0];
            m_flag  = (m_flag & ~clrv) | hit;
            m_cnt   = (m_cnt + 1) & MASK;
            m_rdata = rd;
        end
    end

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        check32({phase, " rdata"}, bus_rdata, m_rdata);
        check32({phase, " R8 irq"}, {28'd0, irq}, {28'd0, m_flag & m_ien});
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = 32'd0;
    endtask

    task automatic rd(input logic [2:0] a);
        bus_addr = a;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        longint tgt;
        idle(3);
        // Reset values: rdata and irq zero, status read zero
        check32("R9 rdata in reset", bus_rdata, 32'd0);
        check32("R9 irq in reset", {28'd0, irq}, 32'd0);
        rst = 1'b0;
        phase = "R9 after reset";
        rd(3'd0); rd(3'd5); rd(3'd6);

        phase = "R2 compare write/read";
        wr(3'd0, 32'd60);
        wr(3'd1, 32'd61);
        wr(3'd2, 32'd400);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd0); rd(3'd1); rd(3'd2); rd(3'd3);

        phase = "R10 unmapped read";
        rd(3'd7); rd(3'd7);

        phase = "R8 enable";
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd6);

        phase = "R3 match sets flag";
        for (int i = 0; i < 450; i++) rd(3'd5);

        phase = "R4 sticky";
        wr(3'd0, 32'd500);
        for (int i = 0; i < 120; i++) rd(3'd5);

        phase = "R5 zero write";
        wr(3'd5, 32'd0);
        rd(3'd5); rd(3'd5);
        phase = "R5 clear one";
        wr(3'd5, 32'd1);
        rd(3'd5); rd(3'd5);
        wr(3'd5, 32'h6);
        rd(3'd5); rd(3'd5);

        phase = "R6 set wins";
        wr(3'd2, 32'(m_cnt + 12));
        tgt = m_cmp[2];
        wr(3'd1, 32'(m_cnt + 4));
        while (m_cnt != tgt) rd(3'd5);
        wr(3'd5, 32'h4);
        rd(3'd5); rd(3'd5);
        check32("R6 flag2 after coincident clear", {31'd0, m_flag[2]}, 32'd1);

        phase = "R7 reserved bits";
        wr(3'd5, 32'hFFFF_FFF0);
        rd(3'd5); rd(3'd5);
        wr(3'd6, 32'h5);
        rd(3'd6); rd(3'd5);

        phase = "R1 counter write ignored";
        wr(3'd4, 32'h0000_0123);
        rd(3'd4); rd(3'd4);

        phase = "R1 counter wrap";
        wr(3'd5, 32'hF);
        for (int i = 0; i < 4200; i++) rd(3'd4);
        phase = "R4 sticky after wrap";
        rd(3'd5); rd(3'd5);

        phase = "R9 mid-run reset";
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        rd(3'd5); rd(3'd0); rd(3'd6); rd(3'd4);
        idle(2);
        finish_run();
    end

endmodule